// File: doc/BRIEF.md
# Pixel Write Address Generator

This block produces the physical row and column address for host writes into a display memory of 80 rows by 104 columns, where each pixel is 12 bits wide. The host positions the write pointer with separate row-load and column-load commands; after that, every pixel write goes to the memory at the current address and then moves the pointer on by one column.

A wrap control picks what happens at the last column. With wrap off, the column stops there. With wrap on, the column returns to zero and the row steps by one, either up or down as the row-direction control selects. Either way, the row wraps around at both ends of the memory. A column-mirror control turns each logical column into its reflected physical column at the moment of the write. Data already held in memory is never touched by it.

The memory array, command decoding and the display-side read path lie outside this block.

Top module: `pix_wr_addr_gen`

## Requirements
- R1: After reset the logical row and column are both 0 and the write strobe is low; the row never leaves 0..79 and the column never leaves 0..103.
- R2: With wrap off, a write at column 103 leaves the column at 103 and the row unchanged.
- R3: With wrap on, a write at column 103 sets the column to 0 and steps the row by one.
- R4: The row step is an increment when the direction input is 0 and a decrement when it is 1.
- R5: An increment from row 79 gives row 0, and a decrement from row 0 gives row 79.
- R6: With mirror set, the physical column output is 103 minus the logical column. With mirror clear, it equals the logical column.
- R7: The write strobe is high exactly in the cycles where a host write is presented, so changing the mirror input never causes a write and never moves the pointer.
- R8: A row load or a column load sets that counter to the supplied value in the next cycle, whatever its previous value was.
- R9: A write uses the current address in the same cycle. The pointer has advanced in the following cycle, so the next write goes to the new location.
- R10: A loaded column above 103 becomes 103, and a loaded row above 79 becomes 79.
- R11: The pixel data output equals the write data input during a write.
- R12: If a load and a write arrive in the same cycle, the write goes to the old address and the loaded counter takes the load value instead of advancing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_set | input | 1 | Load row counter |
| row_set_val | input | 7 | Row value to load |
| col_set | input | 1 | Load column counter |
| col_set_val | input | 7 | Column value to load |
| wrap_en | input | 1 | 1: column wraps to 0 and steps the row |
| row_down | input | 1 | 1: row step decrements, 0: increments |
| col_mirror | input | 1 | 1: physical column is 103 minus logical |
| wr_en | input | 1 | Host pixel write |
| wr_data | input | 12 | Pixel data |
| mem_row | output | 7 | Physical row address |
| mem_col | output | 7 | Physical column address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 12 | Memory write data |

## Verification
The bench builds the block with its default sizes of 80 rows, 104 columns and 12-bit pixels, so both end-of-memory row wraps and the column end are the real boundaries. Loading the counters directly puts every corner (row 0, row 79, column 103) one write away. One scenario walks a complete row of 104 writes to confirm that the wrap lands after exactly that many. The 7-bit load fields can carry values up to 127, so both clamps can be driven.

// File: rtl/pwa_pkg.sv
package pwa_pkg;
  // Saturate a loaded address to the last legal index.
  function automatic int clamp_addr(input int v, input int last);
    return (v > last) ? last : v;
  endfunction

  // Column after one write; saturate or wrap at the last column.
  function automatic int col_after(input int c, input int last, input logic wrap);
    if (c < last) return c + 1;
    return wrap ? 0 : last;
  endfunction

  // Row after one step in the selected direction, wrapping at both ends.
  function automatic int row_after(input int r, input int last, input logic down);
    if (down) return (r == 0) ? last : r - 1;
    return (r == last) ? 0 : r + 1;
  endfunction

  // Physical column for a logical column.
  function automatic int phys_col(input int c, input int last, input logic mirror);
    return mirror ? (last - c) : c;
  endfunction
endpackage

// File: rtl/pwa_col_ctr.sv
module pwa_col_ctr import pwa_pkg::*; #(
  parameter int COLS = 104,
  parameter int CW   = $clog2(COLS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [CW-1:0] ld_val,
  input  logic          adv,
  input  logic          wrap_en,
  output logic [CW-1:0] col_q,
  output logic          row_step_ev
);
  localparam int LAST = COLS - 1;

  // Row moves only when a write wraps the column and no load overrides it.
  assign row_step_ev = adv && !ld && wrap_en && (int'(col_q) == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   col_q <= '0;
    else if (ld)  col_q <= CW'(clamp_addr(int'(ld_val), LAST));
    else if (adv) col_q <= CW'(col_after(int'(col_q), LAST, wrap_en));
  end

  AST_COL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(col_q) <= LAST);  // R1
  AST_COL_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && !wrap_en && int'(col_q) == LAST) |=> int'(col_q) == LAST);  // R2
  AST_COL_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    row_step_ev |=> col_q == '0);  // R3
  AST_COL_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && int'(ld_val) <= LAST) |=> col_q == $past(ld_val));  // R8
  AST_COL_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && int'(ld_val) > LAST) |=> int'(col_q) == LAST);  // R10
  AST_COL_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !ld && int'(col_q) < LAST) |=> col_q == $past(col_q) + 1'b1);  // R9
endmodule

// File: rtl/pwa_row_ctr.sv
module pwa_row_ctr import pwa_pkg::*; #(
  parameter int ROWS = 80,
  parameter int RW   = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld,
  input  logic [RW-1:0] ld_val,
  input  logic          step,
  input  logic          down,
  output logic [RW-1:0] row_q
);
  localparam int LAST = ROWS - 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    row_q <= '0;
    else if (ld)   row_q <= RW'(clamp_addr(int'(ld_val), LAST));
    else if (step) row_q <= RW'(row_after(int'(row_q), LAST, down));
  end

  AST_ROW_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    int'(row_q) <= LAST);  // R1
  AST_ROW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!ld && !step) |=> $stable(row_q));  // R2
  AST_ROW_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && !down && int'(row_q) < LAST) |=> row_q == $past(row_q) + 1'b1);  // R4
  AST_ROW_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && !down && int'(row_q) == LAST) |=> row_q == '0);  // R5
  AST_ROW_BOTTOM_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !ld && down && row_q == '0) |=> int'(row_q) == LAST);  // R5
  AST_ROW_CLAMP: assert property (@(posedge clk) disable iff (!rst_n)
    (ld && int'(ld_val) > LAST) |=> int'(row_q) == LAST);  // R10
endmodule

// File: rtl/pwa_col_map.sv
module pwa_col_map import pwa_pkg::*; #(
  parameter int COLS = 104,
  parameter int CW   = $clog2(COLS)
) (
  input  logic [CW-1:0] log_col,
  input  logic          mirror,
  output logic [CW-1:0] phy_col
);
  localparam int LAST = COLS - 1;
  assign phy_col = CW'(phys_col(int'(log_col), LAST, mirror));
endmodule

// File: rtl/pix_wr_addr_gen.sv
module pix_wr_addr_gen #(
  parameter int ROWS  = 80,
  parameter int COLS  = 104,
  parameter int PIX_W = 12,
  localparam int RW   = $clog2(ROWS),
  localparam int CW   = $clog2(COLS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             row_set,
  input  logic [RW-1:0]    row_set_val,
  input  logic             col_set,
  input  logic [CW-1:0]    col_set_val,
  input  logic             wrap_en,
  input  logic             row_down,
  input  logic             col_mirror,
  input  logic             wr_en,
  input  logic [PIX_W-1:0] wr_data,
  output logic [RW-1:0]    mem_row,
  output logic [CW-1:0]    mem_col,
  output logic             mem_we,
  output logic [PIX_W-1:0] mem_wdata
);
  localparam int COL_LAST = COLS - 1;

  logic [CW-1:0] col_q;
  logic [RW-1:0] row_q;
  logic          row_step_ev;

  pwa_col_ctr #(.COLS(COLS), .CW(CW)) u_col (
    .clk(clk), .rst_n(rst_n), .ld(col_set), .ld_val(col_set_val),
    .adv(wr_en), .wrap_en(wrap_en), .col_q(col_q), .row_step_ev(row_step_ev)
  );

  pwa_row_ctr #(.ROWS(ROWS), .RW(RW)) u_row (
    .clk(clk), .rst_n(rst_n), .ld(row_set), .ld_val(row_set_val),
    .step(row_step_ev), .down(row_down), .row_q(row_q)
  );

  pwa_col_map #(.COLS(COLS), .CW(CW)) u_map (
    .log_col(col_q), .mirror(col_mirror), .phy_col(mem_col)
  );

  assign mem_row   = row_q;
  assign mem_we    = wr_en;
  assign mem_wdata = wr_data;

  AST_MIRROR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    col_mirror |-> (int'(mem_col) + int'(col_q) == COL_LAST));  // R6
  AST_NO_MIRROR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
    !col_mirror |-> mem_col == col_q);  // R6
  AST_IDLE_NO_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !col_set && !row_set) |=> ($stable(col_q) && $stable(row_q)));  // R7
endmodule

// File: tb/tb_pix_wr_addr_gen.sv
module tb_pix_wr_addr_gen;
  localparam int ROWS = 80, COLS = 104, PW = 12;
  localparam int RL = ROWS - 1, CL = COLS - 1;

  logic clk = 0, rst_n = 0;
  logic row_set = 0, col_set = 0, wrap_en = 0, row_down = 0, col_mirror = 0, wr_en = 0;
  logic [6:0] row_set_val = 0, col_set_val = 0;
  logic [PW-1:0] wr_data = 0;
  logic [6:0] mem_row, mem_col;
  logic mem_we;
  logic [PW-1:0] mem_wdata;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  pix_wr_addr_gen #(.ROWS(ROWS), .COLS(COLS), .PIX_W(PW)) dut (
    .clk(clk), .rst_n(rst_n), .row_set(row_set), .row_set_val(row_set_val),
    .col_set(col_set), .col_set_val(col_set_val), .wrap_en(wrap_en),
    .row_down(row_down), .col_mirror(col_mirror), .wr_en(wr_en), .wr_data(wr_data),
    .mem_row(mem_row), .mem_col(mem_col), .mem_we(mem_we), .mem_wdata(mem_wdata)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); @(negedge clk); #1;
  endtask

  task automatic load(input int r, input int c);
    row_set = 1; row_set_val = 7'(r); col_set = 1; col_set_val = 7'(c);
    cyc();
    row_set = 0; col_set = 0;
  endtask

  task automatic write1(input int d);
    wr_en = 1; wr_data = PW'(d);
    cyc();
    wr_en = 0;
  endtask

  task automatic t_reset();
    chk("R1 reset row", mem_row, 0);
    chk("R1 reset col", mem_col, 0);
    chk("R1 reset we", mem_we, 0);
  endtask

  task automatic t_load();
    load(10, 20);
    chk("R8 load row", mem_row, 10);
    chk("R8 load col", mem_col, 20);
    load(100, 127);
    chk("R10 clamp row", mem_row, RL);
    chk("R10 clamp col", mem_col, CL);
    load(3, 4);
    chk("R8 reload row", mem_row, 3);
    chk("R8 reload col", mem_col, 4);
  endtask

  task automatic t_advance();
    wrap_en = 0; load(2, 5);
    wr_en = 1; wr_data = 12'hABC; #1;
    chk("R9 write addr col", mem_col, 5);
    chk("R7 strobe on write", mem_we, 1);
    chk("R11 data pass", mem_wdata, 12'hABC);
    cyc(); wr_en = 0; #1;
    chk("R9 advanced col", mem_col, 6);
    chk("R9 row kept", mem_row, 2);
    chk("R7 strobe off", mem_we, 0);
  endtask

  task automatic t_saturate();
    wrap_en = 0; load(3, 102);
    write1(1); chk("R2 reach end", mem_col, CL);
    write1(2); chk("R2 saturate col", mem_col, CL);
    chk("R2 row unchanged", mem_row, 3);
  endtask

  task automatic t_wrap_dir();
    wrap_en = 1; row_down = 0; load(7, CL);
    write1(3);
    chk("R3 col to zero", mem_col, 0);
    chk("R4 row increment", mem_row, 8);
    row_down = 1; load(7, CL);
    write1(4);
    chk("R3 col to zero dec", mem_col, 0);
    chk("R4 row decrement", mem_row, 6);
  endtask

  task automatic t_row_ends();
    wrap_en = 1; row_down = 0; load(RL, CL);
    write1(5); chk("R5 top wraps to 0", mem_row, 0);
    row_down = 1; load(0, CL);
    write1(6); chk("R5 bottom wraps to 79", mem_row, RL);
    row_down = 0;
  endtask

  task automatic t_full_row();
    wrap_en = 1; row_down = 0; load(20, 0);
    for (int i = 0; i < COLS - 1; i++) write1(i);
    chk("R3 before wrap col", mem_col, CL);
    chk("R3 before wrap row", mem_row, 20);
    write1(7);
    chk("R3 full row col", mem_col, 0);
    chk("R3 full row row", mem_row, 21);
  endtask

  task automatic t_mirror();
    load(5, 10); col_mirror = 1; #1;
    chk("R6 mirror col", mem_col, CL - 10);
    chk("R7 mirror no strobe", mem_we, 0);
    cyc(); cyc();
    col_mirror = 0; #1;
    chk("R7 pointer unmoved", mem_col, 10);
    chk("R7 row unmoved", mem_row, 5);
    load(5, 0); col_mirror = 1; #1;
    chk("R6 mirror col0", mem_col, CL);
    wr_en = 1; wr_data = 12'h123; #1;
    chk("R6 mirrored write", mem_col, CL);
    cyc(); wr_en = 0; #1;
    chk("R6 mirrored next", mem_col, CL - 1);
    col_mirror = 0; #1;
    chk("R6 unmirrored", mem_col, 1);
  endtask

  task automatic t_priority();
    wrap_en = 1; load(9, CL);
    wr_en = 1; wr_data = 12'h055; col_set = 1; col_set_val = 7'd40; #1;
    chk("R12 write old col", mem_col, CL);
    chk("R12 strobe", mem_we, 1);
    cyc(); wr_en = 0; col_set = 0; #1;
    chk("R12 load wins col", mem_col, 40);
    chk("R12 row not stepped", mem_row, 9);
  endtask

  initial begin
    fork
      begin
        @(negedge clk); @(negedge clk); #1;
        t_reset();
        rst_n = 1; @(negedge clk); #1;
        t_load(); t_advance(); t_saturate(); t_wrap_dir();
        t_row_ends(); t_full_row(); t_mirror(); t_priority();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule